// File: doc/BRIEF.md
# Byte-Stream Frame Parser

This block sits behind a serial byte receiver. It takes one byte at a time, given as a one-cycle valid strobe with the byte beside it, and looks for a frame in that stream. A frame opens with the start byte 0xAA. A device ID byte and a length byte follow. Then come exactly that many payload bytes, and the frame closes with the two tail bytes 0xBB and 0x02, in that order.

The parser does not store the payload. Each payload byte goes straight out with a one-cycle valid pulse, and the final one carries a last-byte marker. The captured ID and length are held on outputs, along with a flag that says whether the ID equals the configured device ID. When the tail has been checked, one frame-complete pulse is issued, and a protocol-good flag comes with it. Every output is registered and reacts in the clock cycle after the edge that samples the input strobe.

Top module: `frame_parser`

## Requirements
- R1: In the header-search state, any strobed byte other than 0xAA is dropped and produces no output pulse. 0xAA moves the parser to expect the ID byte.
- R2: The byte after the header appears on `id_out`, and `id_ok` shows whether it equals parameter `DEV_ID` (default 0x01). Both hold until the next ID byte or a reset.
- R3: The byte after the ID appears on `len_out` and holds until the next length byte or a reset.
- R4: Each of the `len_out` payload bytes gives a one-cycle `pay_valid` pulse, with the byte on `pay_byte`, one cycle after its strobe. Payload bytes of any value, including 0xAA and 0xBB, are data.
- R5: `pay_last` is high only together with the pulse of the final payload byte.
- R6: A length of zero produces no payload pulse, and the next two bytes are treated as the tail.
- R7: A tail of 0xBB followed by 0x02 gives one cycle with `frame_done` and `frame_ok` both high. The parser then returns to header search.
- R8: A wrong first tail byte, or a wrong second tail byte, gives `frame_done` with `frame_ok` low at once, and the parser returns to header search. A wrong first tail byte is not itself taken as a header.
- R9: Cycles with `in_valid` low change no state or output. Gaps of any length between bytes of a frame do not change the result.
- R10: A synchronous active-low `rst_n` returns the parser to header search and clears every output to zero.
- R11: `frame_ok` is never high without `frame_done`, and `frame_done` never shares a cycle with `pay_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe: a received byte is on `in_byte` |
| in_byte | input | DATA_W | Received byte |
| id_out | output | DATA_W | ID byte of the latest frame |
| len_out | output | DATA_W | Length byte of the latest frame |
| id_ok | output | 1 | Latest ID equals `DEV_ID` |
| pay_valid | output | 1 | Pulse: a payload byte is on `pay_byte` |
| pay_byte | output | DATA_W | Payload byte |
| pay_last | output | 1 | With `pay_valid`: final payload byte |
| frame_done | output | 1 | Pulse: tail checking has finished |
| frame_ok | output | 1 | With `frame_done`: tail was correct |

## Verification
The bench walks a table of frames. One is a clean three-byte frame with a matching ID. One has leading noise, a zero length and a foreign ID. One has a bad second tail byte. One has a payload that contains 0xAA and 0xBB and then a bad first tail byte, followed by a stray 0x02. These cases separate payload counting from byte-value matching, zero length from a normal length, and the early-abort path from the late-abort path. Directed runs then add idle gaps inside a frame, a 255-byte payload that tests the length counter at its limit, and a reset in the middle of a frame, to show that a stale frame cannot finish.

// File: rtl/frame_parser_pkg.sv
package frame_parser_pkg;

    // Parse position within a frame
    typedef enum logic [2:0] {
        PH_HUNT  = 3'd0,
        PH_ID    = 3'd1,
        PH_LEN   = 3'd2,
        PH_BODY  = 3'd3,
        PH_TAIL0 = 3'd4,
        PH_TAIL1 = 3'd5
    } phase_e;

endpackage

// File: rtl/fp_phase.sv
// Frame sequencer: tracks the position in the frame and the payload bytes
// still to come, and raises one-cycle event strobes for the output stages.
module fp_phase
    import frame_parser_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [DATA_W-1:0] HDR   = 8'hAA,
    parameter logic [DATA_W-1:0] TAIL0 = 8'hBB,
    parameter logic [DATA_W-1:0] TAIL1 = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    output logic              ev_id,
    output logic              ev_len,
    output logic              ev_pay,
    output logic              ev_last,
    output logic              ev_end,
    output logic              ev_good
);

    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO = '0;

    typedef struct packed {
        phase_e            ph;
        logic [DATA_W-1:0] left;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        ev_id   = 1'b0;
        ev_len  = 1'b0;
        ev_pay  = 1'b0;
        ev_last = 1'b0;
        ev_end  = 1'b0;
        ev_good = 1'b0;
        if (in_valid) begin
            case (s_q.ph)
                PH_HUNT: begin
                    if (in_byte == HDR) s_d.ph = PH_ID;
                end
                PH_ID: begin
                    ev_id  = 1'b1;
                    s_d.ph = PH_LEN;
                end
                PH_LEN: begin
                    ev_len   = 1'b1;
                    s_d.left = in_byte;
                    s_d.ph   = (in_byte == ZERO) ? PH_TAIL0 : PH_BODY;
                end
                PH_BODY: begin
                    ev_pay   = 1'b1;
                    s_d.left = s_q.left - ONE;
                    if (s_q.left == ONE) begin
                        ev_last = 1'b1;
                        s_d.ph  = PH_TAIL0;
                    end
                end
                PH_TAIL0: begin
                    if (in_byte == TAIL0) begin
                        s_d.ph = PH_TAIL1;
                    end else begin
                        ev_end = 1'b1;
                        s_d.ph = PH_HUNT;
                    end
                end
                PH_TAIL1: begin
                    ev_end  = 1'b1;
                    ev_good = (in_byte == TAIL1);
                    s_d.ph  = PH_HUNT;
                end
                default: s_d.ph = PH_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph   <= PH_HUNT;
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/fp_hold.sv
// Holds the captured ID, length and ID-match flag between frames.
module fp_hold #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] DEV_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_id,
    input  logic              ev_len,
    input  logic [DATA_W-1:0] in_byte,
    output logic [DATA_W-1:0] id_out,
    output logic [DATA_W-1:0] len_out,
    output logic              id_ok
);

    typedef struct packed {
        logic [DATA_W-1:0] id;
        logic [DATA_W-1:0] len;
        logic              match;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (ev_id) begin
            h_d.id    = in_byte;
            h_d.match = (in_byte == DEV_ID);
        end
        if (ev_len) begin
            h_d.len = in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign id_out  = h_q.id;
    assign len_out = h_q.len;
    assign id_ok   = h_q.match;

endmodule

// File: rtl/fp_stream.sv
// Registers the payload stream and the end-of-frame pulses.
module fp_stream #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_pay,
    input  logic              ev_last,
    input  logic              ev_end,
    input  logic              ev_good,
    input  logic [DATA_W-1:0] in_byte,
    output logic              pay_valid,
    output logic [DATA_W-1:0] pay_byte,
    output logic              pay_last,
    output logic              frame_done,
    output logic              frame_ok
);

    typedef struct packed {
        logic              pv;
        logic [DATA_W-1:0] pb;
        logic              last;
        logic              done;
        logic              ok;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.pv   = ev_pay;
        o_d.last = ev_pay & ev_last;
        o_d.done = ev_end;
        o_d.ok   = ev_end & ev_good;
        if (ev_pay) o_d.pb = in_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign pay_valid  = o_q.pv;
    assign pay_byte   = o_q.pb;
    assign pay_last   = o_q.last;
    assign frame_done = o_q.done;
    assign frame_ok   = o_q.ok;

endmodule

// File: rtl/frame_parser.sv
module frame_parser #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] DEV_ID = 8'h01,
    parameter logic [DATA_W-1:0] HDR    = 8'hAA,
    parameter logic [DATA_W-1:0] TAIL0  = 8'hBB,
    parameter logic [DATA_W-1:0] TAIL1  = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    output logic [DATA_W-1:0] id_out,
    output logic [DATA_W-1:0] len_out,
    output logic              id_ok,
    output logic              pay_valid,
    output logic [DATA_W-1:0] pay_byte,
    output logic              pay_last,
    output logic              frame_done,
    output logic              frame_ok
);

    logic ev_id, ev_len, ev_pay, ev_last, ev_end, ev_good;

    fp_phase #(
        .DATA_W(DATA_W), .HDR(HDR), .TAIL0(TAIL0), .TAIL1(TAIL1)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .ev_id(ev_id), .ev_len(ev_len), .ev_pay(ev_pay), .ev_last(ev_last),
        .ev_end(ev_end), .ev_good(ev_good)
    );

    fp_hold #(
        .DATA_W(DATA_W), .DEV_ID(DEV_ID)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .ev_id(ev_id), .ev_len(ev_len),
        .in_byte(in_byte), .id_out(id_out), .len_out(len_out), .id_ok(id_ok)
    );

    fp_stream #(
        .DATA_W(DATA_W)
    ) u_stream (
        .clk(clk), .rst_n(rst_n), .ev_pay(ev_pay), .ev_last(ev_last),
        .ev_end(ev_end), .ev_good(ev_good), .in_byte(in_byte),
        .pay_valid(pay_valid), .pay_byte(pay_byte), .pay_last(pay_last),
        .frame_done(frame_done), .frame_ok(frame_ok)
    );

endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] id_out,
    input logic [DATA_W-1:0] len_out,
    input logic              id_ok,
    input logic              pay_valid,
    input logic              pay_last,
    input logic              frame_done,
    input logic              frame_ok
);

    // Payload pulses seen since the last frame end or last-byte marker
    logic [DATA_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_done || pay_last) seen_q <= '0;
        else if (pay_valid)                   seen_q <= seen_q + DATA_W'(1);
    end

    assert_pay_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |-> (DATA_W'(seen_q + DATA_W'(1)) == len_out));

    assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |-> pay_valid);

    assert_ok_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> frame_done);

    assert_done_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_done, pay_valid}));

    assert_pulse_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid || frame_done) |-> $past(in_valid));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
            ($stable(id_out) && $stable(len_out) && $stable(id_ok)));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!pay_valid && !pay_last && !frame_done && !frame_ok &&
                    !id_ok && id_out == '0 && len_out == '0));

endmodule

bind frame_parser fp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .id_out(id_out),
    .len_out(len_out), .id_ok(id_ok), .pay_valid(pay_valid),
    .pay_last(pay_last), .frame_done(frame_done), .frame_ok(frame_ok)
);

// File: tb/sim_frame_parser.sv
`timescale 1ns/1ps
module sim_frame_parser;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic [7:0] id_out, len_out, pay_byte;
    logic       id_ok, pay_valid, pay_last, frame_done, frame_ok;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frame_parser #(.DATA_W(8), .DEV_ID(8'h01)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .id_out(id_out), .len_out(len_out), .id_ok(id_ok),
        .pay_valid(pay_valid), .pay_byte(pay_byte), .pay_last(pay_last),
        .frame_done(frame_done), .frame_ok(frame_ok)
    );

    // {byte, pay_valid, pay_last, frame_done, frame_ok, id_ok}
    localparam int NV = 28;
    localparam logic [12:0] VEC [NV] = '{
        // good frame, ID 01, three payload bytes (R1 R2 R3 R4 R5 R7)
        {8'hAA,5'b00000}, {8'h01,5'b00001}, {8'h03,5'b00001},
        {8'h11,5'b10001}, {8'h22,5'b10001}, {8'h33,5'b11001},
        {8'hBB,5'b00001}, {8'h02,5'b00111},
        // noise, foreign ID 07, zero length (R1 R2 R6 R7)
        {8'h55,5'b00001}, {8'h00,5'b00001}, {8'hAA,5'b00001},
        {8'h07,5'b00000}, {8'h00,5'b00000}, {8'hBB,5'b00000},
        {8'h02,5'b00110},
        // bad second tail byte (R8)
        {8'hAA,5'b00000}, {8'h01,5'b00001}, {8'h01,5'b00001},
        {8'h41,5'b11001}, {8'hBB,5'b00001}, {8'h03,5'b00101},
        // payload holding AA/BB, bad first tail byte, stray 02 (R4 R8 R1)
        {8'hAA,5'b00001}, {8'h01,5'b00001}, {8'h02,5'b00001},
        {8'hAA,5'b10001}, {8'hBB,5'b11001}, {8'hCC,5'b00101},
        {8'h02,5'b00001}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one strobe (or idle) for one edge; return 1 ns after that edge
    task automatic step(input logic v, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [12:0] outs();
        return {pay_byte, pay_valid, pay_last, frame_done, frame_ok, id_ok};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check({id_out, len_out, id_ok, pay_valid, pay_last, frame_done, frame_ok} == '0,
              "R10 reset state", {id_out, len_out}, 0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [12:0] got;
            logic [12:0] exp;
            step(1'b1, VEC[i][12:5]);
            got = outs();
            exp = VEC[i];
            if (!exp[4]) begin
                got[12:5] = '0;
                exp[12:5] = '0;
            end
            check(got == exp, "R1-R8 table vector", got, exp);
        end
        check(id_out == 8'h01 && len_out == 8'h02, "R2 R3 held id/len",
              {id_out, len_out}, 16'h0102);

        // gaps inside a frame: idle cycles change nothing (R9)
        step(1'b1, 8'hAA);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 8'h01);
            check(!pay_valid && !frame_done, "R9 idle after header", {pay_valid, frame_done}, 0);
        end
        step(1'b1, 8'h01); step(1'b0, 8'h00);
        step(1'b1, 8'h02); step(1'b0, 8'h00);
        check(len_out == 8'h02 && id_ok, "R9 R3 len across gap", len_out, 8'h02);
        step(1'b1, 8'h5A);
        check(pay_valid && !pay_last && pay_byte == 8'h5A, "R9 R4 first byte", pay_byte, 8'h5A);
        step(1'b0, 8'h00);
        check(!pay_valid && pay_byte == 8'h5A, "R9 no pulse on idle", pay_valid, 0);
        step(1'b1, 8'h6B);
        check(pay_valid && pay_last && pay_byte == 8'h6B, "R5 last byte", {pay_last, pay_byte}, 9'h16B);
        step(1'b0, 8'h00); step(1'b1, 8'hBB); step(1'b0, 8'h00); step(1'b1, 8'h02);
        check(frame_done && frame_ok, "R7 gapped frame good", {frame_done, frame_ok}, 2'b11);
        step(1'b0, 8'h00);
        check(!frame_done && !frame_ok, "R7 done is one cycle", {frame_done, frame_ok}, 0);

        // maximum length payload (R4 R5)
        step(1'b1, 8'hAA); step(1'b1, 8'h01); step(1'b1, 8'hFF);
        check(len_out == 8'hFF, "R3 length 255", len_out, 8'hFF);
        for (int j = 0; j < 255; j++) begin
            step(1'b1, 8'(j ^ 8'h3C));
            check(pay_valid && pay_byte == 8'(j ^ 8'h3C) && (pay_last == (j == 254)),
                  "R4 R5 long payload", {pay_valid, pay_last, pay_byte},
                  {1'b1, (j == 254), 8'(j ^ 8'h3C)});
        end
        step(1'b1, 8'hBB);
        check(!frame_done && !pay_valid, "R7 first tail silent", frame_done, 0);
        step(1'b1, 8'h02);
        check(frame_done && frame_ok, "R7 long frame good", {frame_done, frame_ok}, 2'b11);

        // reset mid-frame (R10)
        step(1'b1, 8'hAA); step(1'b1, 8'h01); step(1'b1, 8'h05); step(1'b1, 8'h11);
        @(negedge clk); rst_n = 1'b0;
        step(1'b1, 8'h22);
        check({id_out, len_out, id_ok, pay_valid, pay_last, frame_done, frame_ok} == '0,
              "R10 reset clears", {id_out, len_out, pay_valid}, 0);
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 8'h33);
        check(!pay_valid && !frame_done, "R10 R1 back to header search", pay_valid, 0);
        step(1'b1, 8'hAA); step(1'b1, 8'h09);
        check(id_out == 8'h09 && !id_ok, "R2 foreign id", {id_ok, id_out}, 9'h009);
        step(1'b1, 8'h01); step(1'b1, 8'h7E);
        check(pay_valid && pay_last && pay_byte == 8'h7E, "R5 single byte", pay_byte, 8'h7E);
        step(1'b1, 8'hBB); step(1'b1, 8'h02);
        check(frame_done && frame_ok, "R7 after reset", {frame_done, frame_ok}, 2'b11);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule